// File: doc/BRIEF.md
# Pseudo-Random Logic Self-Test Engine

This block runs a logic self-test on a circuit under test. One start pulse seeds a pattern generator and clears a response compactor. From the next clock on, the generator puts one pseudo-random stimulus word on the stimulus bus per cycle. The generator is a shift register whose feedback bit is the XOR of selected taps. In the same cycle, the circuit's parallel response is folded into a signature register. That register is a shift register with XOR gates inside the chain, and each response bit enters its own stage.

When the programmed number of patterns has been applied, the engine stops stepping and freezes the signature. It then raises done and reports pass or fail by comparing the final signature with an expected good-machine value. A faulty response can alias to the good signature; this is an accepted property of compaction. Both registers start from defined values at every run, so the signature is repeatable.

The stimulus stream is valid-only and has no back-pressure. The circuit under test must accept a word on every cycle that stim_valid is high. Its response must be present in that same cycle, because it is sampled on the edge that advances the generator. The response bus is ignored while stim_valid is low. expect_sig must be stable from the start pulse until done rises.

Top module: `bist_engine`

## Requirements
- R1: After reset, done, pass, fail and stim_valid are low and signature is zero.
- R2: The clock edge that samples start high loads seed into the generator and clears signature to zero. A seed of zero is replaced by the value 1 (bit 0 set). On the following cycle stim_valid is high and stim_data equals the loaded value.
- R3: While running, each clock moves the generator from s to {s[W-2:0], ^(s & GEN_TAPS)}. The default is W=3 with GEN_TAPS=3'b110, which gives feedback s[2]^s[1] for the polynomial 1 + x + x^3. That generator visits all 7 non-zero states and returns to its start after 7 steps; stim_data is never zero while stim_valid is high.
- R4: Each running clock moves the signature from m to ({m[S-2:0],1'b0}) ^ (m[S-1] ? MISR_POLY : 0) ^ rsp. Response bit i is XORed into stage i, and response bits are zero-extended when the response is narrower than the signature.
- R5: After a start with pat_count = N > 0, stim_valid is high for exactly N consecutive cycles, one pattern per cycle. done rises in the cycle after the last pattern.
- R6: Once done is high, pass is high exactly when the final signature equals expect_sig, and fail is its complement. Neither is ever high without done.
- R7: After done rises, signature stays constant, stim_valid stays low and the response bus has no effect until the next start.
- R8: A start pulse, even in the middle of a run, clears done, pass and fail and begins a fresh run from the new seed.
- R9: A start with pat_count = 0 applies no pattern. done rises on the next cycle with a zero signature, and pass is high only if expect_sig is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that seeds and launches a run |
| seed | input | PG_W | Generator seed, sampled with start |
| pat_count | input | CNT_W | Number of patterns to apply, sampled with start |
| expect_sig | input | SIG_W | Good-machine signature |
| stim_data | output | PG_W | Stimulus word to the circuit under test |
| stim_valid | output | 1 | High on each cycle a stimulus word is applied |
| rsp_data | input | RSP_W | Parallel response of the circuit under test |
| signature | output | SIG_W | Current or final signature |
| done | output | 1 | Run complete |
| pass | output | 1 | Final signature matched |
| fail | output | 1 | Final signature differed |

## Verification
The bench keeps the 3-bit generator at its default taps and builds the compactor 5 bits wide with polynomial 5'b00101. It drives a 3-bit response derived from the stimulus through a small combinational model. Because the response is narrower than the signature, the top stages receive only shifted and fed-back bits, which exercises the zero-extension path. A 5-bit signature also reaches enough states to separate a correct expected value from a corrupted one. A run longer than 7 patterns shows the generator wrapping back to its seed, and a restart in mid-run shows that both registers are reseeded.

// File: rtl/bist_pkg.sv
`timescale 1ns/1ps
package bist_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } bist_phase_e;
endpackage

// File: rtl/bist_patgen.sv
`timescale 1ns/1ps
module bist_patgen #(
  parameter int unsigned PG_W = 3,
  parameter logic [PG_W-1:0] GEN_TAPS = 3'b110
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PG_W-1:0] seed,
  input  logic            advance,
  output logic [PG_W-1:0] state
);
  logic            feedback;
  logic [PG_W-1:0] seed_safe;

  assign feedback  = ^(state & GEN_TAPS);
  assign seed_safe = (seed == '0) ? PG_W'(1) : seed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= '0;
    end else if (load) begin
      state <= seed_safe;
    end else if (advance) begin
      state <= {state[PG_W-2:0], feedback};
    end
  end
endmodule

// File: rtl/bist_misr.sv
`timescale 1ns/1ps
module bist_misr #(
  parameter int unsigned SIG_W = 3,
  parameter int unsigned RSP_W = 3,
  parameter logic [SIG_W-1:0] MISR_POLY = 3'b011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             enable,
  input  logic [RSP_W-1:0] din,
  output logic [SIG_W-1:0] sig,
  output logic [SIG_W-1:0] sig_next
);
  logic [SIG_W-1:0] din_ext;
  logic [SIG_W-1:0] fold;

  generate
    if (RSP_W < SIG_W) begin : g_pad
      assign din_ext = {{(SIG_W-RSP_W){1'b0}}, din};
    end else begin : g_full
      assign din_ext = din[SIG_W-1:0];
    end
  endgenerate

  assign fold     = sig[SIG_W-1] ? MISR_POLY : '0;
  assign sig_next = {sig[SIG_W-2:0], 1'b0} ^ fold ^ din_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig <= '0;
    end else if (clear) begin
      sig <= '0;
    end else if (enable) begin
      sig <= sig_next;
    end
  end
endmodule

// File: rtl/bist_ctrl.sv
`timescale 1ns/1ps
module bist_ctrl
  import bist_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SIG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] pat_count,
  input  logic [SIG_W-1:0] sig_next,
  input  logic [SIG_W-1:0] expect_sig,
  output logic             running,
  output logic             done,
  output logic             pass,
  output logic             fail
);
  bist_phase_e      phase;
  logic [CNT_W-1:0] remain;
  logic             last_pat;
  logic             empty_run;
  logic             final_match;

  assign running     = (phase == PH_RUN);
  assign last_pat    = running && (remain == CNT_W'(1));
  assign empty_run   = (pat_count == '0);
  assign final_match = (sig_next == expect_sig);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      remain <= '0;
      done   <= 1'b0;
      pass   <= 1'b0;
      fail   <= 1'b0;
    end else if (start) begin
      remain <= pat_count;
      if (empty_run) begin
        phase <= PH_DONE;
        done  <= 1'b1;
        pass  <= (expect_sig == '0);
        fail  <= (expect_sig != '0);
      end else begin
        phase <= PH_RUN;
        done  <= 1'b0;
        pass  <= 1'b0;
        fail  <= 1'b0;
      end
    end else if (running) begin
      remain <= remain - 1'b1;
      if (last_pat) begin
        phase <= PH_DONE;
        done  <= 1'b1;
        pass  <= final_match;
        fail  <= !final_match;
      end
    end
  end
endmodule

// File: rtl/bist_engine.sv
`timescale 1ns/1ps
module bist_engine #(
  parameter int unsigned PG_W  = 3,
  parameter int unsigned SIG_W = 3,
  parameter int unsigned RSP_W = 3,
  parameter int unsigned CNT_W = 16,
  parameter logic [PG_W-1:0]  GEN_TAPS  = 3'b110,
  parameter logic [SIG_W-1:0] MISR_POLY = 3'b011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PG_W-1:0]  seed,
  input  logic [CNT_W-1:0] pat_count,
  input  logic [SIG_W-1:0] expect_sig,
  output logic [PG_W-1:0]  stim_data,
  output logic             stim_valid,
  input  logic [RSP_W-1:0] rsp_data,
  output logic [SIG_W-1:0] signature,
  output logic             done,
  output logic             pass,
  output logic             fail
);
  logic             running;
  logic [SIG_W-1:0] sig_next;
  logic             step;

  assign step       = running && !start;
  assign stim_valid = running;

  bist_patgen #(
    .PG_W(PG_W), .GEN_TAPS(GEN_TAPS)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .load(start), .seed(seed),
    .advance(step), .state(stim_data)
  );

  bist_misr #(
    .SIG_W(SIG_W), .RSP_W(RSP_W), .MISR_POLY(MISR_POLY)
  ) u_misr (
    .clk(clk), .rst_n(rst_n), .clear(start), .enable(step),
    .din(rsp_data), .sig(signature), .sig_next(sig_next)
  );

  bist_ctrl #(
    .CNT_W(CNT_W), .SIG_W(SIG_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_count(pat_count),
    .sig_next(sig_next), .expect_sig(expect_sig),
    .running(running), .done(done), .pass(pass), .fail(fail)
  );
endmodule

// File: rtl/bist_engine_chk.sv
`timescale 1ns/1ps
module bist_engine_chk #(
  parameter int unsigned PG_W  = 3,
  parameter int unsigned SIG_W = 3,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] pat_count,
  input logic [PG_W-1:0]  stim_data,
  input logic             stim_valid,
  input logic [SIG_W-1:0] signature,
  input logic             done,
  input logic             pass,
  input logic             fail
);
  AST_START_CLEARS_SIG: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (signature == '0)); // R2
  AST_STIM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stim_valid |-> (stim_data != '0)); // R3
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail)); // R6
  AST_VERDICT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pass || fail) |-> done); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !stim_valid); // R7
  AST_SIG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(signature)); // R7
  AST_RESTART_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && pat_count != '0) |=> (stim_valid && !done && !pass && !fail)); // R8
  AST_EMPTY_RUN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && pat_count == '0) |=> (done && !stim_valid)); // R9
endmodule

bind bist_engine bist_engine_chk #(
  .PG_W(PG_W), .SIG_W(SIG_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pat_count(pat_count),
  .stim_data(stim_data), .stim_valid(stim_valid), .signature(signature),
  .done(done), .pass(pass), .fail(fail)
);

// File: tb/bist_engine_test.sv
`timescale 1ns/1ps
module bist_engine_test;
  localparam int unsigned G = 3;
  localparam int unsigned S = 5;
  localparam int unsigned R = 3;
  localparam int unsigned C = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [G-1:0] seed = '0;
  logic [C-1:0] pat_count = '0;
  logic [S-1:0] expect_sig = '0;
  logic [G-1:0] stim_data;
  logic         stim_valid;
  logic [R-1:0] rsp_data;
  logic [S-1:0] signature;
  logic         done, pass, fail;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  // circuit under test stand-in
  assign rsp_data = {stim_data[0] ^ stim_data[2], stim_data[1] & stim_data[2], ~stim_data[0]};

  bist_engine #(
    .PG_W(G), .SIG_W(S), .RSP_W(R), .CNT_W(C),
    .GEN_TAPS(3'b110), .MISR_POLY(5'b00101)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .pat_count(pat_count),
    .expect_sig(expect_sig), .stim_data(stim_data), .stim_valid(stim_valid),
    .rsp_data(rsp_data), .signature(signature), .done(done), .pass(pass), .fail(fail)
  );

  function automatic logic [G-1:0] gen_ref(input logic [G-1:0] s);
    return {s[1:0], s[2] ^ s[1]};
  endfunction

  function automatic logic [R-1:0] cut_ref(input logic [G-1:0] s);
    return {s[0] ^ s[2], s[1] & s[2], ~s[0]};
  endfunction

  function automatic logic [S-1:0] misr_ref(input logic [S-1:0] m, input logic [R-1:0] r);
    return {m[3:0], 1'b0} ^ (m[4] ? 5'b00101 : 5'b00000) ^ {2'b00, r};
  endfunction

  function automatic logic [S-1:0] sig_ref(input logic [G-1:0] sd, input int n);
    logic [G-1:0] g = (sd == '0) ? 3'd1 : sd;
    logic [S-1:0] m = '0;
    for (int i = 0; i < n; i++) begin
      m = misr_ref(m, cut_ref(g));
      g = gen_ref(g);
    end
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // full run; good=1 gives the correct expected signature
  task automatic t_run(input logic [G-1:0] sd, input int n, input bit good);
    logic [G-1:0] g = (sd == '0) ? 3'd1 : sd;
    logic [S-1:0] m = '0;
    logic [S-1:0] want = sig_ref(sd, n);
    @(negedge clk);
    seed = sd; pat_count = C'(n);
    expect_sig = good ? want : (want ^ 5'b10000);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R2 signature cleared", 32'(signature), 32'd0);
    chk("R8 verdict cleared", {29'd0, done, pass, fail}, 32'd0);
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      chk("R5 stim_valid high", 32'(stim_valid), 32'd1);
      chk("R3 stimulus", 32'(stim_data), 32'(g));
      chk("R4 running signature", 32'(signature), 32'(m));
      m = misr_ref(m, cut_ref(g));
      g = gen_ref(g);
      @(posedge clk);
    end
    @(negedge clk);
    chk("R5 done after last pattern", {30'd0, done, stim_valid}, 32'd2);
    chk("R4 final signature", 32'(signature), 32'(want));
    chk("R6 verdict", {30'd0, pass, fail}, good ? 32'd2 : 32'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 signature frozen", 32'(signature), 32'(want));
      chk("R7 stimulus idle", 32'(stim_valid), 32'd0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 flags at reset", {28'd0, done, pass, fail, stim_valid}, 32'd0);
    chk("R1 signature at reset", 32'(signature), 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_wrap();
    // 8 patterns from 011: the eighth equals the seed again
    logic [G-1:0] g = 3'b011;
    @(negedge clk);
    seed = 3'b011; pat_count = C'(8); expect_sig = sig_ref(3'b011, 8);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 7) chk("R3 period of 7", 32'(stim_data), 32'h3);
      else chk("R3 sequence", 32'(stim_data), 32'(g));
      g = gen_ref(g);
      @(posedge clk);
    end
    @(negedge clk);
    chk("R6 wrap run passes", {29'd0, done, pass, fail}, 32'd6);
  endtask

  task automatic t_empty();
    @(negedge clk);
    seed = 3'b101; pat_count = '0; expect_sig = '0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R9 empty run pass", {28'd0, done, pass, fail, stim_valid}, 32'hC);
    chk("R9 empty signature", 32'(signature), 32'd0);
    expect_sig = 5'd1; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R9 empty run fail", {28'd0, done, pass, fail, stim_valid}, 32'hA);
  endtask

  task automatic t_restart();
    @(negedge clk);
    seed = 3'b110; pat_count = C'(7); expect_sig = '0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 mid-run not done", {30'd0, done, stim_valid}, 32'd1);
    t_run(3'b101, 4, 1'b1);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    t_reset();
    t_run(3'b001, 7, 1'b1);     // R3 R4 R6 full period, good signature
    t_run(3'b100, 12, 1'b0);    // R6 corrupted expected value fails
    t_run(3'b000, 5, 1'b1);     // R2 zero seed replaced by 1
    t_wrap();                   // R3
    t_empty();                  // R9
    t_restart();                // R8
    t_run(3'b111, 1, 1'b1);     // R5 single pattern
    finish_up();
  end
endmodule